// File: doc/BRIEF.md
# Error Interrupt Status Unit

This unit collects six error event strobes from a bus controller into sticky status bits. Each strobe lasts one cycle. Software reads the bits back in two views. The raw view shows every event that has occurred. The enabled view shows only the events that are also enabled in the mask.

A write of ones to the enabled-view address acknowledges the matching bits. The mask has no single register. Software changes it through a set address and a clear address. A combined interrupt line is high while any enabled bit is pending. A separate fatal flag is high while an enabled bit of the fatal class is pending.

The register port is a plain single-cycle interface. Writes take effect on the rising clock edge. Read data is a combinational function of the address.

Top module: `err_irq_unit`

## Requirements
- R1: Reset clears all status bits and all enable bits, so every readable register returns 0 and both `irq_o` and `fatal_o` are low.
- R2: An event on `evt_i[k]` sets status bit k at the next clock edge whether or not bit k is enabled. The bit stays set until it is acknowledged. Bit meanings: 0 system, 1 fatal, 2 non-fatal, 3 correctable, 4 bus tag-lookup fatal, 5 ECRC.
- R3: Reading address 0x1C0 returns the raw status in bits [5:0]. Reading 0x1C4 returns raw status AND enable.
- R4: A write to 0x1C4 clears each status bit whose write-data bit is 1 and leaves the other status bits unchanged.
- R5: If an event on bit k and an acknowledge of bit k arrive in the same cycle, bit k remains set.
- R6: A write to 0x1C8 sets the enable bits that are 1 in the write data. A write to 0x1CC clears the enable bits that are 1 in the write data. Zero bits have no effect in both cases. Reads of 0x1C8 and 0x1CC both return the enable mask in bits [5:0].
- R7: `irq_o` is high exactly while at least one bit of raw status AND enable is set.
- R8: `fatal_o` is high exactly while enabled status bit 1 or enabled status bit 4 is set.
- R9: Bits above bit 5 always read 0. Writes to 0x1C0 and to undecoded addresses change nothing. Undecoded addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 6 | One-cycle error event strobes, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` (combinational) |
| irq_o | output | 1 | Combined enabled error interrupt |
| fatal_o | output | 1 | Enabled fatal-class error pending |

## Verification
Event strobes, acknowledges and mask writes are sampled on one rising edge. Their effect shows one edge later in the status and enable registers, and `irq_o` and `fatal_o` follow in that same cycle with no extra delay. Read data depends on the current address and state with no pipeline stage. The bench drives every stimulus at a falling edge and removes it at the next falling edge, so exactly one rising edge lies between them. It then sets the read address and samples a nanosecond later, well before the next rising edge.

// File: rtl/err_irq_unit.sv
module err_irq_unit #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NUM_EV = 6,
  parameter logic [NUM_EV-1:0] FATAL_SEL = 6'b010010,
  parameter logic [ADDR_W-1:0] RAW_ADDR = 12'h1C0,
  parameter logic [ADDR_W-1:0] MSK_ADDR = 12'h1C4,
  parameter logic [ADDR_W-1:0] SET_ADDR = 12'h1C8,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 12'h1CC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fatal_o
);

  logic [NUM_EV-1:0] raw_q, en_q, masked, wsel, ack;
  logic hit_raw, hit_msk, hit_set, hit_clr;

  assign hit_raw = addr_i == RAW_ADDR;
  assign hit_msk = addr_i == MSK_ADDR;
  assign hit_set = addr_i == SET_ADDR;
  assign hit_clr = addr_i == CLR_ADDR;

  assign wsel   = wdata_i[NUM_EV-1:0];
  assign ack    = (wr_en_i && hit_msk) ? wsel : '0;
  assign masked = raw_q & en_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= (raw_q & ~ack) | evt_i;
      if (wr_en_i && hit_set)      en_q <= en_q | wsel;
      else if (wr_en_i && hit_clr) en_q <= en_q & ~wsel;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_raw)                rdata_o[NUM_EV-1:0] = raw_q;
    else if (hit_msk)           rdata_o[NUM_EV-1:0] = masked;
    else if (hit_set | hit_clr) rdata_o[NUM_EV-1:0] = en_q;
  end

  assign irq_o   = |masked;
  assign fatal_o = |(masked & FATAL_SEL);

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (raw_q == '0 && en_q == '0));

  // also covers R5: an event wins over a same-cycle acknowledge
  assert_event_sticks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_msk && evt_i == '0) |=> ((raw_q & $past(wsel)) == '0));

  assert_enable_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_set) |=> ((en_q & $past(wsel)) == $past(wsel)));

  assert_enable_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_clr) |=> ((en_q & $past(wsel)) == '0));

  assert_fatal_implies_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> irq_o);

  assert_raw_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_raw && evt_i == '0) |=> (raw_q == $past(raw_q)));

endmodule

// File: tb/err_irq_unit_tb.sv
`timescale 1ns/1ps
module err_irq_unit_tb;
  localparam logic [11:0] A_RAW = 12'h1C0, A_MSK = 12'h1C4, A_SET = 12'h1C8, A_CLR = 12'h1CC;
  localparam logic [5:0] FAT = 6'b010010;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [5:0] evt = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, fatal;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  err_irq_unit u_dut (.clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fatal_o(fatal));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(logic [5:0] e, logic w, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    evt = e; wr_en = w; addr = a; wdata = d;
    @(negedge clk);
    evt = '0; wr_en = 0; wdata = '0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(A_RAW, d); chk("R1 raw", d, 0);
    rd(A_MSK, d); chk("R1 masked", d, 0);
    rd(A_SET, d); chk("R1 enable", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 fatal", {31'b0, fatal}, 0);

    for (int e = 0; e < 64; e++) begin
      cyc('0, 1, A_CLR, 32'h3F);
      cyc('0, 1, A_SET, e);
      rd(A_CLR, d); chk("R6 enable readback", d, e);
      for (int p = 0; p < 64; p++) begin
        logic [5:0] pe, w, left;
        pe = 6'(p) & 6'(e);
        cyc(6'(p), 0, A_RAW, 0);
        rd(A_RAW, d); chk("R2 raw latch", d, p);
        rd(A_MSK, d); chk("R3 masked view", d, pe);
        chk("R7 irq", {31'b0, irq}, {31'b0, |pe});
        chk("R8 fatal", {31'b0, fatal}, {31'b0, |(pe & FAT)});
        w = 6'(p) ^ 6'(e);
        left = 6'(p) & ~w;
        cyc('0, 1, A_MSK, {26'h3FFFFFF, w});
        rd(A_RAW, d); chk("R4 ack clears ones only", d, left);
        chk("R7 irq after ack", {31'b0, irq}, {31'b0, |(left & 6'(e))});
        cyc('0, 1, A_MSK, 32'h3F);
      end
    end

    // R5 event beats same-cycle acknowledge
    cyc('0, 1, A_SET, 32'h3F);
    cyc(6'h02, 0, A_RAW, 0);
    cyc(6'h01, 1, A_MSK, 32'h03);
    rd(A_RAW, d); chk("R5 event wins bit0, bit1 cleared", d, 32'h01);
    cyc(6'h3F, 1, A_MSK, 32'h3F);
    rd(A_RAW, d); chk("R5 all bits kept", d, 32'h3F);
    cyc('0, 1, A_MSK, 32'h3F);
    rd(A_RAW, d); chk("R4 final clear", d, 0);

    // R6 zero bits leave enables alone
    cyc('0, 1, A_CLR, 32'h3F);
    cyc('0, 1, A_SET, 32'h15);
    cyc('0, 1, A_SET, 32'h02);
    rd(A_SET, d); chk("R6 set or-in", d, 32'h17);
    cyc('0, 1, A_CLR, 32'h05);
    rd(A_CLR, d); chk("R6 clear and-not", d, 32'h12);

    // R9 upper bits, raw address writes, undecoded addresses
    cyc('0, 1, A_SET, 32'hFFFFFFFF);
    rd(A_SET, d); chk("R9 upper bits read zero", d, 32'h3F);
    cyc(6'h08, 0, A_RAW, 0);
    cyc('0, 1, A_RAW, 32'hFFFFFFFF);
    rd(A_RAW, d); chk("R9 raw write ignored", d, 32'h08);
    cyc('0, 1, 12'h1D0, 32'hFFFFFFFF);
    cyc('0, 1, 12'h0C8, 32'hFFFFFFFF);
    rd(A_RAW, d); chk("R9 stray write keeps status", d, 32'h08);
    rd(A_SET, d); chk("R9 stray write keeps enable", d, 32'h3F);
    rd(12'h1D0, d); chk("R9 undecoded reads zero", d, 0);
    rd(12'h0C4, d); chk("R9 alias-free decode", d, 0);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(A_RAW, d); chk("R1 reset clears raw", d, 0);
    rd(A_SET, d); chk("R1 reset clears enable", d, 0);
    chk("R1 irq low after reset", {31'b0, irq}, 0);
    summary();
  end
endmodule